// File: doc/BRIEF.md
# Memory attribute resolution unit

This unit produces the final access attributes for an address that has already been translated. The leaf descriptor does not carry a memory type. It carries a small attribute index instead, and that index selects one byte of a programmable eight-entry indirection table. The selected byte is decoded into a memory class and a cache policy. The unit then applies these steps in order:

1. Permission overrides collected from upper-level table entries are applied on top of the leaf's own permission bits.
2. When stage 2 translation is enabled, the stage 2 attribute set is merged in, and the more restrictive value is kept for each attribute.

The result has these fields: memory class, cache policy, reorderability, read and write permission, execute-never, and physical address space. It also carries a flag that marks the requested access type as not permitted. The result is registered and is presented one cycle after the request.

Software-like configuration reaches the unit through a write-only port with address, data and write enable. Each write lands in one table entry.

Each table entry is decoded as follows:
- Bit 7 set selects Normal memory.
- Bit 7 clear selects Device memory.
- For Normal memory, bits 1:0 give the cache policy: 0 is non-cacheable, 1 is write-through, and 2 or 3 is write-back.
- Bits 6:2 are reserved.

The stage 2 cache policy input uses the same 2-bit code.

Top module: `mattr_resolve_unit`

## Requirements
- R1: While reset is high, and after it, rsp_valid and every rsp field read 0, and all eight table entries read as 0, which decodes as Device.
- R2: rsp_valid rises exactly one cycle after a cycle with req_valid high. The rsp fields are captured from the inputs of that request cycle. In a cycle without req_valid, rsp_valid is 0 in the next cycle and the rsp fields keep their previous values.
- R3: req_attr_idx selects table entry N. Entry bit 7 set gives Normal memory with rsp_reorder=1, and rsp_cache is entry bits 1:0 with code 3 reported as 2 (write-back). Entry bit 7 clear gives Device memory with rsp_cache=0 (non-cacheable) and rsp_reorder=0.
- R4: A table write with cfg_we high in cycle T affects requests presented in cycle T+1 and later. A request presented in cycle T itself still sees the old entry value.
- R5: Each table-level override that is set replaces the leaf value. req_tbl_ro forces write permission to 0, req_tbl_xn forces execute-never to 1, and req_tbl_ns forces the address space bit to 1.
- R6: When a table-level override bit is clear, the matching leaf bit passes through unchanged (leaf read permission always passes).
- R7: With req_s2_en=1, the following merge rules apply:
  - The result is Device if either stage is Device, and then the cache policy is 0.
  - Otherwise the cache policy is the numerically smaller of the two decoded policies (0 < 1 < 2).
  - Read and write permissions are ANDed, and execute-never is ORed.
  - The address space bit comes from stage 1 only.
- R8: With req_s2_en=0, the stage 1 result is output unmodified whatever the stage 2 inputs hold.
- R9: rsp_fault is 1 when the resolved permissions forbid the access selected by req_acc:
  - Code 0 (read) faults without read permission.
  - Code 1 (write) faults without write permission.
  - Code 2 (execute) faults when execute-never is set.
  - Code 3 is reserved and always faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table entry write enable |
| cfg_addr | input | 3 | Table entry number to write |
| cfg_wdata | input | 8 | Table entry value |
| req_valid | input | 1 | Request present this cycle |
| req_attr_idx | input | 3 | Leaf attribute index |
| req_leaf_rd | input | 1 | Leaf read permission |
| req_leaf_wr | input | 1 | Leaf write permission |
| req_leaf_xn | input | 1 | Leaf execute-never |
| req_leaf_ns | input | 1 | Leaf address space (1 = non-secure) |
| req_tbl_ro | input | 1 | Table-level override: remove write |
| req_tbl_xn | input | 1 | Table-level override: force execute-never |
| req_tbl_ns | input | 1 | Table-level override: force non-secure |
| req_s2_en | input | 1 | Stage 2 merge enable |
| req_s2_normal | input | 1 | Stage 2 memory class (1 = Normal) |
| req_s2_cache | input | 2 | Stage 2 cache policy code |
| req_s2_rd | input | 1 | Stage 2 read permission |
| req_s2_wr | input | 1 | Stage 2 write permission |
| req_s2_xn | input | 1 | Stage 2 execute-never |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result valid |
| rsp_normal | output | 1 | Resolved class (1 = Normal) |
| rsp_cache | output | 2 | Resolved cache policy |
| rsp_reorder | output | 1 | Accesses may be reordered |
| rsp_rd | output | 1 | Resolved read permission |
| rsp_wr | output | 1 | Resolved write permission |
| rsp_xn | output | 1 | Resolved execute-never |
| rsp_ns | output | 1 | Resolved address space |
| rsp_fault | output | 1 | Requested access not permitted |

## Verification
Every resolved field and the fault flag are due at the first rising edge after the request cycle. Inputs are driven at the falling edge, and each check samples one nanosecond after the next rising edge, so each check looks at exactly one registered result.

A table write is due at that same edge. The bench's shadow copy of the table is therefore updated only after the check of the cycle that carried the write. This lets a request issued in the same cycle as a write be compared against the old entry value.

Idle cycles are checked at the same point: rsp_valid must be low and the fields must still hold the previous result.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

    localparam int unsigned ATTR_ENTRIES = 8;
    localparam int unsigned ATTR_W       = 8;
    localparam int unsigned ATTR_IDX_W   = $clog2(ATTR_ENTRIES);
    localparam int unsigned CLASS_BIT    = 7;

    typedef enum logic [1:0] {
        CP_NONCACHE = 2'd0,
        CP_WTHRU    = 2'd1,
        CP_WBACK    = 2'd2
    } cache_pol_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic       normal;
        cache_pol_e cache;
        logic       reorder;
        logic       rd;
        logic       wr;
        logic       xn;
        logic       ns;
    } attr_set_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic xn;
        logic ns;
    } leaf_perm_t;

    typedef struct packed {
        logic ro;
        logic xn;
        logic ns;
    } tbl_ovr_t;

    typedef struct packed {
        logic       normal;
        cache_pol_e cache;
        logic       rd;
        logic       wr;
        logic       xn;
    } s2_attr_t;

    // Two-bit policy code to policy; code 3 is folded onto write-back.
    function automatic cache_pol_e decode_cache(input logic [1:0] code);
        cache_pol_e pol;
        case (code)
            2'd0:    pol = CP_NONCACHE;
            2'd1:    pol = CP_WTHRU;
            default: pol = CP_WBACK;
        endcase
        return pol;
    endfunction

    // Less cacheable policy of two.
    function automatic cache_pol_e weaker_cache(input cache_pol_e a, input cache_pol_e b);
        return (a < b) ? a : b;
    endfunction

    // Permission check of one access type against a resolved set.
    function automatic logic perm_denied(input attr_set_t s, input acc_e acc);
        logic deny;
        case (acc)
            ACC_READ:  deny = ~s.rd;
            ACC_WRITE: deny = ~s.wr;
            ACC_EXEC:  deny = s.xn;
            default:   deny = 1'b1;
        endcase
        return deny;
    endfunction

endpackage

// File: rtl/mattr_indir_regs.sv
module mattr_indir_regs
    import mattr_pkg::*;
#(
    parameter int unsigned ENTRIES   = ATTR_ENTRIES,
    parameter int unsigned ENTRY_W   = ATTR_W,
    parameter logic [ENTRY_W-1:0] RESET_VAL = '0,
    localparam int unsigned IDX_W    = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [ENTRY_W-1:0] rdata
);

    logic [ENTRIES-1:0] hit;
    logic [ENTRY_W-1:0] mem_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
        assign hit[g] = we && (int'(waddr) == g);
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (rst) begin
                mem_q[i] <= RESET_VAL;
            end else if (hit[i]) begin
                mem_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (int'(raddr) == i) begin
                rdata = mem_q[i];
            end
        end
    end

endmodule

// File: rtl/mattr_s1_resolve.sv
module mattr_s1_resolve
    import mattr_pkg::*;
#(
    parameter int unsigned ENTRY_W = ATTR_W,
    parameter int unsigned NORM_B  = CLASS_BIT
) (
    input  logic [ENTRY_W-1:0] entry,
    input  leaf_perm_t         leaf,
    input  tbl_ovr_t           ovr,
    output attr_set_t          s1
);

    logic       is_normal;
    cache_pol_e pol;
    logic       unused_rsvd_bits;

    assign is_normal = entry[NORM_B];
    assign pol       = is_normal ? decode_cache(entry[1:0]) : CP_NONCACHE;

    // Reserved bits carry no meaning.
    assign unused_rsvd_bits = ^{entry, 1'b0} ^ entry[NORM_B] ^ (^entry[1:0]);

    always_comb begin
        s1         = '0;
        s1.normal  = is_normal;
        s1.cache   = pol;
        s1.reorder = is_normal;
        s1.rd      = leaf.rd;
        s1.wr      = leaf.wr & ~ovr.ro;
        s1.xn      = leaf.xn | ovr.xn;
        s1.ns      = leaf.ns | ovr.ns;
    end

endmodule

// File: rtl/mattr_s2_merge.sv
module mattr_s2_merge
    import mattr_pkg::*;
(
    input  attr_set_t s1,
    input  s2_attr_t  s2,
    input  logic      s2_en,
    input  acc_e      acc,
    output attr_set_t res,
    output logic      fault
);

    attr_set_t  merged;
    logic       both_normal;
    cache_pol_e s2_pol;

    assign s2_pol      = s2.normal ? s2.cache : CP_NONCACHE;
    assign both_normal = s1.normal & s2.normal;

    always_comb begin
        merged         = s1;
        merged.normal  = both_normal;
        merged.cache   = both_normal ? weaker_cache(s1.cache, s2_pol) : CP_NONCACHE;
        merged.reorder = both_normal;
        merged.rd      = s1.rd & s2.rd;
        merged.wr      = s1.wr & s2.wr;
        merged.xn      = s1.xn | s2.xn;
        merged.ns      = s1.ns;
    end

    assign res   = s2_en ? merged : s1;
    assign fault = perm_denied(res, acc);

endmodule

// File: rtl/mattr_resolve_unit.sv
module mattr_resolve_unit
    import mattr_pkg::*;
#(
    parameter int unsigned ENTRIES = ATTR_ENTRIES,
    parameter int unsigned ENTRY_W = ATTR_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_addr,
    input  logic [ENTRY_W-1:0] cfg_wdata,
    input  logic               req_valid,
    input  logic [IDX_W-1:0]   req_attr_idx,
    input  logic               req_leaf_rd,
    input  logic               req_leaf_wr,
    input  logic               req_leaf_xn,
    input  logic               req_leaf_ns,
    input  logic               req_tbl_ro,
    input  logic               req_tbl_xn,
    input  logic               req_tbl_ns,
    input  logic               req_s2_en,
    input  logic               req_s2_normal,
    input  logic [1:0]         req_s2_cache,
    input  logic               req_s2_rd,
    input  logic               req_s2_wr,
    input  logic               req_s2_xn,
    input  logic [1:0]         req_acc,
    output logic               rsp_valid,
    output logic               rsp_normal,
    output logic [1:0]         rsp_cache,
    output logic               rsp_reorder,
    output logic               rsp_rd,
    output logic               rsp_wr,
    output logic               rsp_xn,
    output logic               rsp_ns,
    output logic               rsp_fault
);

    logic [ENTRY_W-1:0] sel_entry;
    leaf_perm_t         leaf;
    tbl_ovr_t           ovr;
    s2_attr_t           s2;
    attr_set_t          s1_set;
    attr_set_t          fin_set;
    logic               fin_fault;

    attr_set_t          out_q;
    logic               fault_q;
    logic               valid_q;

    assign leaf      = '{rd: req_leaf_rd, wr: req_leaf_wr, xn: req_leaf_xn, ns: req_leaf_ns};
    assign ovr       = '{ro: req_tbl_ro, xn: req_tbl_xn, ns: req_tbl_ns};
    assign s2.normal = req_s2_normal;
    assign s2.cache  = decode_cache(req_s2_cache);
    assign s2.rd     = req_s2_rd;
    assign s2.wr     = req_s2_wr;
    assign s2.xn     = req_s2_xn;

    mattr_indir_regs #(
        .ENTRIES (ENTRIES),
        .ENTRY_W (ENTRY_W)
    ) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (req_attr_idx),
        .rdata (sel_entry)
    );

    mattr_s1_resolve #(
        .ENTRY_W (ENTRY_W)
    ) s1_i (
        .entry (sel_entry),
        .leaf  (leaf),
        .ovr   (ovr),
        .s1    (s1_set)
    );

    mattr_s2_merge s2_i (
        .s1    (s1_set),
        .s2    (s2),
        .s2_en (req_s2_en),
        .acc   (acc_e'(req_acc)),
        .res   (fin_set),
        .fault (fin_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            out_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                out_q   <= fin_set;
                fault_q <= fin_fault;
            end
        end
    end

    assign rsp_valid   = valid_q;
    assign rsp_normal  = out_q.normal;
    assign rsp_cache   = out_q.cache;
    assign rsp_reorder = out_q.reorder;
    assign rsp_rd      = out_q.rd;
    assign rsp_wr      = out_q.wr;
    assign rsp_xn      = out_q.xn;
    assign rsp_ns      = out_q.ns;
    assign rsp_fault   = fault_q;

endmodule

// File: rtl/mattr_resolve_chk.sv
module mattr_resolve_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_leaf_rd,
    input logic       req_leaf_ns,
    input logic       req_tbl_ro,
    input logic       req_tbl_xn,
    input logic       req_tbl_ns,
    input logic       req_s2_en,
    input logic       req_s2_normal,
    input logic       req_s2_xn,
    input logic [1:0] req_acc,
    input logic       rsp_valid,
    input logic       rsp_normal,
    input logic [1:0] rsp_cache,
    input logic       rsp_reorder,
    input logic       rsp_rd,
    input logic       rsp_wr,
    input logic       rsp_xn,
    input logic       rsp_ns,
    input logic       rsp_fault
);

    // R2
    a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R2
    a_r2_idle_next: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R2
    a_r2_hold_fields: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable({rsp_normal, rsp_cache, rsp_reorder, rsp_rd,
                                rsp_wr, rsp_xn, rsp_ns, rsp_fault}));
    // R3
    a_r3_device_uncached: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_normal |-> (rsp_cache == 2'd0) && !rsp_reorder);
    // R3
    a_r3_cache_code: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_cache != 2'd3);
    // R5
    a_r5_tbl_ro: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_tbl_ro |=> !rsp_wr);
    // R5
    a_r5_tbl_xn: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_tbl_xn |=> rsp_xn);
    // R7
    a_r7_ns_stage1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_ns == $past(req_leaf_ns | req_tbl_ns));
    // R7
    a_r7_s2_device: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_s2_en && !req_s2_normal |=> !rsp_normal);
    // R7
    a_r7_s2_xn: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_s2_en && req_s2_xn |=> rsp_xn);
    // R8
    a_r8_s2_off_rd: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_s2_en |=> rsp_rd == $past(req_leaf_rd));
    // R9
    a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_acc == 2'd3) |=> rsp_fault);
    // R9
    a_r9_read_fault: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_acc == 2'd0) |=> rsp_fault == !rsp_rd);

endmodule

bind mattr_resolve_unit mattr_resolve_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_leaf_rd   (req_leaf_rd),
    .req_leaf_ns   (req_leaf_ns),
    .req_tbl_ro    (req_tbl_ro),
    .req_tbl_xn    (req_tbl_xn),
    .req_tbl_ns    (req_tbl_ns),
    .req_s2_en     (req_s2_en),
    .req_s2_normal (req_s2_normal),
    .req_s2_xn     (req_s2_xn),
    .req_acc       (req_acc),
    .rsp_valid     (rsp_valid),
    .rsp_normal    (rsp_normal),
    .rsp_cache     (rsp_cache),
    .rsp_reorder   (rsp_reorder),
    .rsp_rd        (rsp_rd),
    .rsp_wr        (rsp_wr),
    .rsp_xn        (rsp_xn),
    .rsp_ns        (rsp_ns),
    .rsp_fault     (rsp_fault)
);

// File: tb/mattr_resolve_unit_tb_top.sv
`timescale 1ns/1ps
module mattr_resolve_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [2:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic       req_valid;
    logic [2:0] req_attr_idx;
    logic       req_leaf_rd, req_leaf_wr, req_leaf_xn, req_leaf_ns;
    logic       req_tbl_ro, req_tbl_xn, req_tbl_ns;
    logic       req_s2_en, req_s2_normal;
    logic [1:0] req_s2_cache;
    logic       req_s2_rd, req_s2_wr, req_s2_xn;
    logic [1:0] req_acc;
    logic       rsp_valid, rsp_normal, rsp_reorder, rsp_rd, rsp_wr, rsp_xn, rsp_ns, rsp_fault;
    logic [1:0] rsp_cache;

    logic [7:0] shadow [8];
    logic [8:0] last_exp;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    mattr_resolve_unit dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_attr_idx(req_attr_idx),
        .req_leaf_rd(req_leaf_rd), .req_leaf_wr(req_leaf_wr),
        .req_leaf_xn(req_leaf_xn), .req_leaf_ns(req_leaf_ns),
        .req_tbl_ro(req_tbl_ro), .req_tbl_xn(req_tbl_xn), .req_tbl_ns(req_tbl_ns),
        .req_s2_en(req_s2_en), .req_s2_normal(req_s2_normal), .req_s2_cache(req_s2_cache),
        .req_s2_rd(req_s2_rd), .req_s2_wr(req_s2_wr), .req_s2_xn(req_s2_xn),
        .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_normal(rsp_normal), .rsp_cache(rsp_cache),
        .rsp_reorder(rsp_reorder), .rsp_rd(rsp_rd), .rsp_wr(rsp_wr),
        .rsp_xn(rsp_xn), .rsp_ns(rsp_ns), .rsp_fault(rsp_fault)
    );

    function automatic logic [1:0] pol_of(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    // Expected {normal, cache, reorder, rd, wr, xn, ns, fault} from the requirements.
    function automatic logic [8:0] model(input logic [7:0] ent);
        logic       nrm, rd, wr, xn, ns, flt;
        logic [1:0] c, c2;
        nrm = ent[7];
        c   = nrm ? pol_of(ent[1:0]) : 2'd0;
        rd  = req_leaf_rd;
        wr  = req_leaf_wr & ~req_tbl_ro;
        xn  = req_leaf_xn | req_tbl_xn;
        ns  = req_leaf_ns | req_tbl_ns;
        if (req_s2_en) begin
            c2  = req_s2_normal ? pol_of(req_s2_cache) : 2'd0;
            nrm = nrm & req_s2_normal;
            c   = nrm ? ((c < c2) ? c : c2) : 2'd0;
            rd  = rd & req_s2_rd;
            wr  = wr & req_s2_wr;
            xn  = xn | req_s2_xn;
        end
        case (req_acc)
            2'd0:    flt = ~rd;
            2'd1:    flt = ~wr;
            2'd2:    flt = xn;
            default: flt = 1'b1;
        endcase
        return {nrm, c, nrm, rd, wr, xn, ns, flt};
    endfunction

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic idle_inputs();
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_attr_idx = '0;
        {req_leaf_rd, req_leaf_wr, req_leaf_xn, req_leaf_ns} = '0;
        {req_tbl_ro, req_tbl_xn, req_tbl_ns} = '0;
        {req_s2_en, req_s2_normal, req_s2_rd, req_s2_wr, req_s2_xn} = '0;
        req_s2_cache = '0; req_acc = '0;
    endtask

    task automatic rand_req();
        logic [31:0] r;
        r = $urandom;
        req_attr_idx  = r[2:0];
        req_leaf_rd   = r[3];  req_leaf_wr = r[4]; req_leaf_xn = r[5]; req_leaf_ns = r[6];
        req_tbl_ro    = r[7] & r[8]; req_tbl_xn = r[9] & r[10]; req_tbl_ns = r[11] & r[12];
        req_s2_en     = r[13]; req_s2_normal = r[14] | r[15]; req_s2_cache = r[17:16];
        req_s2_rd     = r[18] | r[19]; req_s2_wr = r[20] | r[21]; req_s2_xn = r[22] & r[23];
        req_acc       = r[25:24];
    endtask

    // Inputs are set after a falling edge; this samples 1 ns after the next rising edge.
    task automatic step(input string tag);
        logic [8:0] e;
        logic       v;
        v = req_valid;
        e = v ? model(shadow[req_attr_idx]) : last_exp;
        @(posedge clk); #1;
        check(tag, {rsp_valid, rsp_normal, rsp_cache, rsp_reorder, rsp_rd, rsp_wr,
                    rsp_xn, rsp_ns, rsp_fault}, {v, e});
        last_exp = e;
        if (cfg_we) shadow[cfg_addr] = cfg_wdata;
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        idle_inputs();
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step("R4 write cycle idle");
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fail++;
            $display("FAIL R2 watchdog: got no completion, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f3c_5a77));
        for (int i = 0; i < 8; i++) shadow[i] = 8'h00;
        last_exp = '0;
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {rsp_valid, rsp_normal, rsp_cache, rsp_reorder, rsp_rd,
                                   rsp_wr, rsp_xn, rsp_ns, rsp_fault}, 10'd0);
        @(negedge clk);
        rst = 1'b0;
        step("R1 idle after reset");

        // R1: every entry reads as Device after reset.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            idle_inputs();
            req_valid = 1'b1; req_attr_idx = 3'(i); req_leaf_rd = 1'b1; req_leaf_wr = 1'b1;
            step("R1 reset entry is Device");
        end

        // R4: write in the same cycle as a request to that entry.
        @(negedge clk);
        idle_inputs();
        cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 8'h82;
        req_valid = 1'b1; req_attr_idx = 3'd3; req_leaf_rd = 1'b1;
        step("R4 same-cycle sees old");
        @(negedge clk);
        idle_inputs();
        req_valid = 1'b1; req_attr_idx = 3'd3; req_leaf_rd = 1'b1;
        step("R4 next cycle sees new");

        // R3: each cache code, including 3 reported as write-back.
        cfg_write(3'd0, 8'h80);
        cfg_write(3'd1, 8'h81);
        cfg_write(3'd2, 8'h7f);
        cfg_write(3'd4, 8'h83);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            idle_inputs();
            req_valid = 1'b1; req_attr_idx = 3'(i);
            step("R3 entry decode");
        end

        // R2: idle cycle with changed inputs keeps fields.
        @(negedge clk);
        idle_inputs();
        req_attr_idx = 3'd4; req_leaf_wr = 1'b1; req_tbl_xn = 1'b1;
        step("R2 hold without request");

        // R5 / R6: overrides set and clear.
        @(negedge clk);
        idle_inputs();
        req_valid = 1'b1; req_attr_idx = 3'd4;
        {req_leaf_rd, req_leaf_wr, req_leaf_xn, req_leaf_ns} = 4'b1100;
        {req_tbl_ro, req_tbl_xn, req_tbl_ns} = 3'b111; req_acc = 2'd1;
        step("R5 overrides set");
        @(negedge clk);
        req_tbl_ro = 1'b0; req_tbl_xn = 1'b0; req_tbl_ns = 1'b0; req_leaf_xn = 1'b1;
        req_acc = 2'd2;
        step("R6 overrides clear");

        // R7: stage 2 device over stage 1 normal; cache minimum.
        @(negedge clk);
        idle_inputs();
        req_valid = 1'b1; req_attr_idx = 3'd4; req_leaf_rd = 1'b1; req_leaf_wr = 1'b1;
        req_s2_en = 1'b1; req_s2_normal = 1'b0; req_s2_rd = 1'b1; req_s2_wr = 1'b0;
        req_acc = 2'd1;
        step("R7 s2 device wins");
        @(negedge clk);
        req_s2_normal = 1'b1; req_s2_cache = 2'd1; req_s2_xn = 1'b1; req_acc = 2'd2;
        step("R7 cache minimum");

        // R8: stage 2 disabled ignores restrictive stage 2 inputs.
        @(negedge clk);
        req_s2_en = 1'b0; req_s2_normal = 1'b0; req_s2_rd = 1'b0; req_acc = 2'd0;
        step("R8 s2 disabled pass");

        // R9: reserved access type always faults.
        @(negedge clk);
        req_acc = 2'd3;
        step("R9 reserved faults");

        // Mixed random traffic.
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] r;
            @(negedge clk);
            idle_inputs();
            r = $urandom;
            cfg_we = (r[3:0] == 4'd0); cfg_addr = r[6:4]; cfg_wdata = r[15:8];
            rand_req();
            req_valid = (r[19:16] != 4'd0);
            step("R7 R9 random mix");
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule